// File: doc/BRIEF.md
# Half-Duplex Line Direction and Transmit-Interrupt Controller

This block sits next to a UART transmitter on a half-duplex RS-485 link. It owns the direction pin of the line driver. When a byte enters the transmit FIFO, the pin switches to the transmit level. After the final queued character has fully left the shifter, the block waits one extra bit time and then hands the line back to receive. The wait covers the last stop bit on the far side of the line.

The same block produces the transmit interrupt request. In automatic direction mode the request waits until the shift register is empty. In standard mode it behaves like a 16550 holding-register-empty interrupt and fires as soon as the FIFO drains, even while the shifter is still sending. A polarity bit inverts the direction pin for drivers that enable on the opposite level. The FIFO, the shifter and the baud generator are outside the block; only their status flags and strobes come in.

Top module: `rs485_dir_ctrl`

## Requirements
- R1: With `auto_en` high, a `stop_done` pulse seen while `fifo_empty` is high starts a hold-off. The direction pin goes to the receive level on the clock edge that samples the TICKS_PER_BIT-th `tick16` pulse (default 16). Only pulses on cycles after the `stop_done` cycle are counted. Before that edge the pin stays at the transmit level.
- R2: With `auto_en` high, a cycle with `fifo_wr` high puts the direction pin at the transmit level from the next cycle on.
- R3: A `fifo_wr` during the hold-off cancels the pending release. The pin stays at the transmit level, and a later release again needs a fresh `stop_done` and a full bit time of ticks.
- R4: A `stop_done` pulse while `fifo_empty` is low does not start a release, so the pin stays at the transmit level between characters.
- R5: With `auto_en` high, `tx_irq` is high in the cycle after a cycle in which `fifo_empty` is high, `tsr_busy` is low and `fifo_wr` is low. It does not rise while `tsr_busy` is high.
- R6: With `auto_en` low, `tx_irq` is high in the cycle after any cycle in which `fifo_empty` is high and `fifo_wr` is low, whatever `tsr_busy` is.
- R7: A cycle with `fifo_wr` high makes `tx_irq` low in the next cycle. A write takes priority over any set condition.
- R8: The transmit level of `dir_out` equals `dir_inv` and the receive level is its complement. So with `dir_inv` low the pin is high while receiving. A change of `dir_inv` shows on the pin in the same cycle.
- R9: During and right after reset, `dir_out` is at the receive level, no hold-off is running and `tx_irq` is low.
- R10: While `auto_en` is low, `dir_out` is at the receive level from the cycle after `auto_en` was sampled low. Raising `auto_en` while idle leaves the pin at the receive level until the next write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_en | input | 1 | Automatic direction mode enable |
| dir_inv | input | 1 | Direction pin polarity invert |
| fifo_wr | input | 1 | Strobe: a byte was written to the transmit FIFO |
| fifo_empty | input | 1 | Transmit FIFO holds no characters |
| tsr_busy | input | 1 | Transmit shift register is sending |
| stop_done | input | 1 | Pulse: the stop bit of the current character has completed |
| tick16 | input | 1 | Enable at sixteen times the baud rate |
| dir_out | output | 1 | Line driver direction pin |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
A behavioural model follows the traffic through single-byte frames and back-to-back two-byte bursts. The bursts show whether the release waits for the last character instead of the first stop bit. A byte written inside the hold-off window tells a cancelled release apart from one that only restarts its count. Repeating a frame with the polarity bit set shows whether the inversion sits on the pin or inside the state. Standard mode is tried with the shifter still busy while the FIFO is empty, which exposes an interrupt gated by the wrong flag.

// File: rtl/rs485_dir_ctrl.sv
module rs485_dir_ctrl #(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic auto_en,
  input  logic dir_inv,
  input  logic fifo_wr,
  input  logic fifo_empty,
  input  logic tsr_busy,
  input  logic stop_done,
  input  logic tick16,
  output logic dir_out,
  output logic tx_irq
);

  localparam int CW = $clog2(TICKS_PER_BIT + 1);
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_BIT - 1);

  logic          drive_q;
  logic          hold_q;
  logic [CW-1:0] cnt_q;
  logic          irq_q;

  wire last_tick = hold_q && tick16 && (cnt_q == LAST);
  wire irq_set   = fifo_empty && (!auto_en || !tsr_busy);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_q <= 1'b0;
      hold_q  <= 1'b0;
      cnt_q   <= '0;
    end else if (!auto_en) begin
      drive_q <= 1'b0;
      hold_q  <= 1'b0;
      cnt_q   <= '0;
    end else if (fifo_wr) begin
      drive_q <= 1'b1;
      hold_q  <= 1'b0;
      cnt_q   <= '0;
    end else if (stop_done && fifo_empty) begin
      hold_q  <= 1'b1;
      cnt_q   <= '0;
    end else if (last_tick) begin
      drive_q <= 1'b0;
      hold_q  <= 1'b0;
      cnt_q   <= '0;
    end else if (hold_q && tick16) begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq_q <= 1'b0;
    else if (fifo_wr) irq_q <= 1'b0;
    else if (irq_set) irq_q <= 1'b1;
  end

  assign dir_out = drive_q ? dir_inv : ~dir_inv;
  assign tx_irq  = irq_q;

  p_release_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(drive_q) && $past(auto_en)) |-> $past(hold_q && tick16));

  p_write_drives_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && fifo_wr) |=> (dir_out == dir_inv));

  p_write_cancels_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && fifo_wr) |=> (!hold_q && cnt_q == '0));

  p_no_midburst_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && stop_done && !fifo_empty && !fifo_wr && !hold_q) |=> !hold_q);

  p_irq_waits_shifter_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tx_irq) && $past(auto_en)) |-> $past(fifo_empty && !tsr_busy));

  p_write_clears_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |=> !tx_irq);

  p_disabled_receive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_en |=> (dir_out == ~dir_inv));

endmodule

// File: tb/tb_rs485_dir_ctrl.sv
`timescale 1ns/1ps
module tb_rs485_dir_ctrl;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic auto_en = 1'b0, dir_inv = 1'b0, fifo_wr = 1'b0, fifo_empty = 1'b1;
  logic tsr_busy = 1'b0, stop_done = 1'b0, tick16 = 1'b0;
  logic dir_out, tx_irq;

  int n_cmp = 0, n_bad = 0;
  int qcnt = 0;
  int tdiv = 0;
  string phase = "R9";

  int m_tx = 0, m_wait = -1, m_irq = 0;

  always #5 clk = ~clk;

  rs485_dir_ctrl #(.TICKS_PER_BIT(16)) dut (
    .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .dir_inv(dir_inv),
    .fifo_wr(fifo_wr), .fifo_empty(fifo_empty), .tsr_busy(tsr_busy),
    .stop_done(stop_done), .tick16(tick16), .dir_out(dir_out), .tx_irq(tx_irq)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  always @(negedge clk) begin
    tdiv = (tdiv + 1) % 3;
    tick16 <= (tdiv == 0);
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_tx = 0; m_wait = -1; m_irq = 0;
    end else begin
      if (!auto_en) begin
        m_tx = 0; m_wait = -1;
      end else if (fifo_wr) begin
        m_tx = 1; m_wait = -1;
      end else if (stop_done && fifo_empty) begin
        m_wait = 0;
      end else if (m_wait >= 0 && tick16) begin
        m_wait++;
        if (m_wait == 16) begin m_tx = 0; m_wait = -1; end
      end
      if (fifo_wr) m_irq = 0;
      else if (fifo_empty && (!auto_en || !tsr_busy)) m_irq = 1;
    end
    #2;
    chk(phase, "dir_out vs model", dir_out, m_tx ? dir_inv : ~dir_inv);
    chk(phase, "tx_irq vs model", tx_irq, m_irq[0]);
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_byte();
    @(negedge clk); fifo_wr = 1'b1;
    @(negedge clk); fifo_wr = 1'b0; fifo_empty = 1'b0; qcnt++;
  endtask

  task automatic shift_one();
    @(negedge clk); qcnt--; fifo_empty = (qcnt == 0); tsr_busy = 1'b1;
    cyc(30);
    @(negedge clk); stop_done = 1'b1; tsr_busy = 1'b0;
    @(negedge clk); stop_done = 1'b0;
  endtask

  initial begin
    phase = "R9";
    cyc(4);
    chk("R9", "dir_out in reset", dir_out, 1'b1);
    chk("R9", "tx_irq in reset", tx_irq, 1'b0);
    rst_n = 1'b1;
    chk("R9", "dir_out after reset", dir_out, 1'b1);

    phase = "R10";
    cyc(3);
    chk("R10", "dir_out disabled", dir_out, 1'b1);
    auto_en = 1'b1;
    cyc(2);
    chk("R10", "enable while idle keeps receive", dir_out, 1'b1);

    phase = "R5";
    chk("R5", "irq with idle shifter", tx_irq, 1'b1);

    phase = "R2";
    write_byte();
    chk("R2", "dir_out after write", dir_out, 1'b0);
    chk("R7", "irq cleared by write", tx_irq, 1'b0);

    phase = "R5";
    shift_one();
    phase = "R1";
    cyc(20);
    chk("R1", "still transmit in hold-off", dir_out, 1'b0);
    cyc(40);
    chk("R1", "released after bit time", dir_out, 1'b1);

    phase = "R4";
    write_byte();
    write_byte();
    shift_one();
    cyc(60);
    chk("R4", "no release between characters", dir_out, 1'b0);
    shift_one();
    phase = "R1";
    cyc(60);
    chk("R1", "release after burst", dir_out, 1'b1);

    phase = "R3";
    write_byte();
    shift_one();
    cyc(20);
    write_byte();
    cyc(60);
    chk("R3", "write cancels release", dir_out, 1'b0);
    shift_one();
    cyc(20);
    chk("R3", "full bit time after restart", dir_out, 1'b0);
    cyc(40);
    chk("R3", "released after restart", dir_out, 1'b1);

    phase = "R8";
    @(negedge clk); dir_inv = 1'b1;
    #1 chk("R8", "inverted receive level", dir_out, 1'b0);
    write_byte();
    chk("R8", "inverted transmit level", dir_out, 1'b1);
    shift_one();
    cyc(60);
    chk("R8", "inverted release", dir_out, 1'b0);
    @(negedge clk); dir_inv = 1'b0;

    phase = "R10";
    write_byte();
    @(negedge clk); auto_en = 1'b0;
    cyc(1);
    chk("R10", "disable forces receive", dir_out, 1'b1);

    phase = "R6";
    @(negedge clk); qcnt--; fifo_empty = 1'b1; tsr_busy = 1'b1;
    cyc(2);
    chk("R6", "standard irq while shifter busy", tx_irq, 1'b1);
    phase = "R7";
    write_byte();
    chk("R7", "write clears standard irq", tx_irq, 1'b0);
    phase = "R6";
    @(negedge clk); qcnt--; fifo_empty = 1'b1;
    cyc(2);
    chk("R6", "standard irq again", tx_irq, 1'b1);
    @(negedge clk); tsr_busy = 1'b0;
    cyc(5);

    summary();
    $finish;
  end

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

endmodule